// File: doc/BRIEF.md
# Auto-Reload Baud Rate Generator

This block produces the bit-rate timing strobe for a serial port. An 8-bit up-counter advances on count strobes. A count strobe comes either on every cycle of the peripheral clock or on every sixth cycle, chosen by a speed-select input. When the counter passes its top value it restarts from an 8-bit reload value. The stream of overflows is then either halved by a toggle stage or passed through unchanged, chosen by a doubling input. The result is a one-cycle tick that stays synchronous to the peripheral clock.

Software normally picks the reload value, the speed and the doubling setting, then raises the enable. The tick period in peripheral clock cycles is (256 - reload) × (1 or 6) × (2 or 1). Clearing the enable parks the generator in its reset state. The next time it is enabled, the counter starts again from zero.

Top module: `baudGen`

## Requirements
- R1: While reset (rstN low) is applied, baudTick is 0, and the counter, the prescaler and the halving toggle are zero.
- R2: With speedFast = 1 the counter advances on every clock. With speedFast = 0 it advances once every 6 clocks, and the first advance comes on the sixth clock edge after enable rises.
- R3: While enable is 0, the counter, the prescaler and the toggle are held at zero, and baudTick stays 0.
- R4: An overflow happens when the counter is 0xFF and a count strobe arrives. On that edge the counter loads reloadVal, so the overflow period is (256 - reloadVal) count strobes. With reloadVal = 0xFF the counter overflows on every count strobe.
- R5: After enable rises, the counter starts from 0, so the first overflow needs 256 count strobes.
- R6: With rateDouble = 1 every overflow produces a tick. With rateDouble = 0 only every second overflow produces a tick, the first one being the second overflow after enable rises.
- R7: baudTick is exactly the registered overflow decision. It is high for the one cycle that follows the edge at which the counter reloads, and it is never high in any other cycle.
- R8: A change to reloadVal in the middle of a period does not change the count in progress. It takes effect at the next overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; when low, all state is held cleared |
| speedFast | input | 1 | 1: count every clock; 0: count every 6th clock |
| rateDouble | input | 1 | 1: bypass the divide-by-two stage |
| reloadVal | input | 8 | Value loaded into the counter on overflow |
| baudTick | output | 1 | One-cycle baud strobe |

## Verification
Three things can land on the same clock edge: an overflow, a reload, and the flip of the halving toggle. A change to reloadVal can also coincide with an overflow. The bench provokes this by setting reloadVal to 0xFF, which makes the counter overflow on every strobe, and by rewriting reloadVal on the cycle right after a tick. A behavioural model that keeps its own counters is compared with baudTick on every clock. Separate interval measurements confirm that the old value finishes the current period and that the new value sets the next one.

// File: rtl/baudGenPkg.sv
package baudGenPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;   // advance the counter this cycle
    logic clearAll;  // hold the counter at zero
  } ctrlStrobe_t;
endpackage

// File: rtl/baudGenDatapath.sv
module baudGenDatapath
  import baudGenPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             overflow,
  output logic [CNT_W-1:0] cntVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  assign overflow = strobe.countEn && (cnt == CNT_MAX);
  assign cntVal   = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.clearAll) cnt <= '0;
    else if (overflow)        cnt <= reloadVal;
    else if (strobe.countEn)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/baudGenControl.sv
module baudGenControl
  import baudGenPkg::*;
#(
  parameter int PRESCALE = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        speedFast,
  input  logic        rateDouble,
  input  logic        overflow,
  output ctrlStrobe_t strobe,
  output logic        baudTick
);
  logic preWrap;

  generate
    if (PRESCALE > 1) begin : g_prescale
      localparam int PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] preCnt;

      assign preWrap = (preCnt == PRE_LAST);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        preCnt <= '0;
        else if (!enable) preCnt <= '0;
        else if (preWrap) preCnt <= '0;
        else              preCnt <= preCnt + 1'b1;
      end
    end else begin : g_noPrescale
      assign preWrap = 1'b1;
    end
  endgenerate

  logic halfToggle;
  logic tickNext;

  assign strobe.clearAll = !enable;
  assign strobe.countEn  = enable && (speedFast || preWrap);
  assign tickNext        = overflow && (rateDouble || halfToggle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfToggle <= 1'b0;
      baudTick   <= 1'b0;
    end else if (!enable) begin
      halfToggle <= 1'b0;
      baudTick   <= 1'b0;
    end else begin
      if (overflow) halfToggle <= !halfToggle;
      baudTick <= tickNext;
    end
  end
endmodule

// File: rtl/baudGen.sv
module baudGen
  import baudGenPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             speedFast,
  input  logic             rateDouble,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             baudTick
);
  ctrlStrobe_t      strobe;
  logic             overflow;
  logic [CNT_W-1:0] cntVal;

  baudGenControl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .speedFast(speedFast),
    .rateDouble(rateDouble), .overflow(overflow), .strobe(strobe),
    .baudTick(baudTick)
  );

  baudGenDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .overflow(overflow), .cntVal(cntVal)
  );
endmodule

// File: rtl/baudGenChecker.sv
module baudGenChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             speedFast,
  input logic             rateDouble,
  input logic [CNT_W-1:0] reloadVal,
  input logic             countEn,
  input logic             overflow,
  input logic [CNT_W-1:0] cntVal,
  input logic             baudTick
);
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!baudTick && cntVal == '0));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (enable && overflow) |=> (cntVal == $past(reloadVal)));

  a_r2_increment: assert property (@(posedge clk) disable iff (!rstN)
    (enable && countEn && !overflow) |=> (cntVal == $past(cntVal) + 1'b1));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !countEn) |=> $stable(cntVal));

  a_r2_fast_every: assert property (@(posedge clk) disable iff (!rstN)
    (enable && speedFast) |-> countEn);

  a_r2_slow_gap: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !speedFast && countEn) |=> !countEn);

  a_r6_double_tick: assert property (@(posedge clk) disable iff (!rstN)
    (enable && overflow && rateDouble) |=> baudTick);

  a_r7_tick_cause: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> ($past(overflow) && $past(enable)));
endmodule

bind baudGen baudGenChecker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .speedFast(speedFast),
  .rateDouble(rateDouble), .reloadVal(reloadVal), .countEn(strobe.countEn),
  .overflow(overflow), .cntVal(cntVal), .baudTick(baudTick)
);

// File: tb/tb_baudGen.sv
module tb_baudGen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       speedFast = 1'b1;
  logic       rateDouble = 1'b1;
  logic [7:0] reloadVal = 8'h00;
  logic       baudTick;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // behavioural reference state
  int  mPre = 0, mCnt = 0;
  bit  mTog = 0, mTick = 0;

  baudGen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .speedFast(speedFast),
    .rateDouble(rateDouble), .reloadVal(reloadVal), .baudTick(baudTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN || !enable) begin
      mPre = 0; mCnt = 0; mTog = 0; mTick = 0;
    end else begin
      bit strobeNow, ovfNow;
      strobeNow = speedFast || (mPre == 5);
      mPre = (mPre == 5) ? 0 : mPre + 1;
      ovfNow = strobeNow && (mCnt == 255);
      mTick = ovfNow && (rateDouble || mTog);
      if (ovfNow) begin
        mTog = !mTog;
        mCnt = reloadVal;
      end else if (strobeNow) begin
        mCnt = mCnt + 1;
      end
    end
  end

  // R7: every-cycle comparison of the tick against the model
  always @(negedge clk) begin
    cycles++;
    compared++;
    if (baudTick !== mTick) begin
      mismatched++;
      $display("FAIL R7 cycle %0d: baudTick=%0b expected %0b", cycles, baudTick, mTick);
    end
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: run exceeded %0d cycles (actual) vs limit (expected)", WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic waitTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baudTick && n < 5000);
  endtask

  task automatic restart(input bit fast, input bit dbl, input logic [7:0] rl);
    @(negedge clk);
    enable = 1'b0;
    speedFast = fast; rateDouble = dbl; reloadVal = rl;
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 tick during reset", baudTick, 0);
    rstN = 1'b1;

    // R5: first tick after enable, fast and doubled, needs 256 strobes
    restart(1, 1, 8'hF0);
    waitTick(n);
    check("R5 first period", n, 256);
    // R4: auto-reload period
    waitTick(n);
    check("R4 reload period F0", n, 16);
    waitTick(n);
    check("R4 reload period F0 again", n, 16);

    // R8: change reload right after a tick
    reloadVal = 8'h00;
    waitTick(n);
    check("R8 old period kept", n, 16);
    waitTick(n);
    check("R8 new period used", n, 256);

    // R6: halved rate
    restart(1, 0, 8'hF0);
    waitTick(n);
    check("R6 first halved tick", n, 256 + 16);
    waitTick(n);
    check("R6 halved period", n, 32);

    // R2: slow prescale, doubled, reload FE
    restart(0, 1, 8'hFE);
    waitTick(n);
    check("R2 slow first period", n, 256 * 6);
    waitTick(n);
    check("R2 slow period", n, 12);
    rateDouble = 1'b0;
    waitTick(n);
    waitTick(n);
    check("R2 slow halved period", n, 24);

    // R4: reload FF, overflow on every strobe
    restart(1, 1, 8'hFF);
    waitTick(n);
    waitTick(n);
    check("R4 reload FF period", n, 1);
    waitTick(n);
    check("R4 reload FF period again", n, 1);

    // R3: disable mid-run, no ticks
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      if (baudTick) n++;
      @(negedge clk);
    end
    check("R3 ticks while disabled", n, 0);
    // R3/R5: re-enable restarts from zero
    reloadVal = 8'hF0;
    enable = 1'b1;
    waitTick(n);
    check("R3 restart from zero", n, 256);

    // R1: reset in mid-run clears state
    reloadVal = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 tick after reset applied", baudTick, 0);
    rstN = 1'b1;
    reloadVal = 8'hF0;
    waitTick(n);
    check("R1 first period after reset", n, 256);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule